// File: doc/BRIEF.md
# Per-Output PWM Gate Combiner

This block produces the gate-enable bits for a bank of sixteen low-side drivers. Each output has a software on/off bit and a PWM-enable bit. When PWM is enabled, the output combines one shared PWM pin with its on/off bit. A per-output select bit chooses whether that combination is an AND or an OR. When PWM is disabled, the shared pin has no effect on the output.

Eight of the sixteen outputs also have a dedicated parallel PWM pin. While PWM is disabled, that pin is ORed with the on/off bit. While PWM is enabled, the pin is ignored. A fault controller can force any single output low, or force all outputs low at once.

All PWM pins are asynchronous to the block clock, so each passes through a two-flop synchroniser. The final gate vector is registered. The control registers and shutdown requests therefore reach the gates one clock after they are sampled. A PWM pin reaches its gate three clocks after it is sampled.

Top module: `pwm_gate_matrix`

## Requirements
- R1: While reset (active low) is asserted, every gate bit is 0, and after release every gate stays 0 until driven otherwise.
- R2: With an output's PWM-enable bit at 1 and its select bit at 0, its gate equals the synchronised shared PWM pin AND its on/off bit.
- R3: With an output's PWM-enable bit at 1 and its select bit at 1, its gate equals the synchronised shared PWM pin OR its on/off bit.
- R4: With an output's PWM-enable bit at 1, its dedicated parallel pin has no effect on its gate.
- R5: With an output's PWM-enable bit at 0, the shared PWM pin has no effect on its gate.
- R6: With PWM-enable at 0, an output that owns a dedicated pin has gate = on/off bit OR synchronised dedicated pin. Dedicated pin bit k drives the k-th such output in ascending order. With the default map, bits 0..7 drive outputs 0, 1, 6, 7, 8, 9, 14 and 15.
- R7: With PWM-enable at 0, an output without a dedicated pin has gate equal to its on/off bit.
- R8: A per-output shutdown bit at 1 forces that output's gate to 0 on the next clock, whatever the other inputs are.
- R9: The global shutdown input at 1 forces all gate bits to 0 on the next clock.
- R10: A change on a control or shutdown input appears at the gates one clock later. A change on any PWM pin appears three clocks later: two synchroniser flops plus the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| out_on_i | input | 16 | On/off bit per output (1 = on) |
| pwm_en_i | input | 16 | PWM-enable bit per output (1 = use shared pin) |
| pwm_or_i | input | 16 | Combine select per output (0 = AND, 1 = OR) |
| pwm_glb_i | input | 1 | Shared PWM pin, asynchronous |
| pwm_ded_i | input | 8 | Dedicated parallel PWM pins, asynchronous |
| shdn_i | input | 16 | Per-output shutdown request from the fault controller |
| shdn_all_i | input | 1 | Global shutdown request |
| gate_o | output | 16 | Registered gate-enable bits |

## Verification
Four properties are checked on every clock:
- the reset clear;
- the two shutdown overrides, each one clock after its request;
- the rule that an output with no dedicated pin and PWM disabled follows its on/off bit.

These checks relate inputs only to the gate outputs. Other behaviours pass through the synchroniser delay and cannot be checked that way: the AND/OR combining with the shared pin, the routing of dedicated pins, and the suppression of the pin that is not selected. Those are shown by the bench scenarios, which compare every cycle against a model with delayed pin histories. The exact three-clock pin latency is shown the same way.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    localparam int unsigned MAP_MAX_W = 64;

    typedef enum logic {
        COMB_AND = 1'b0,
        COMB_OR  = 1'b1
    } comb_mode_e;

    // number of outputs that own a dedicated pin
    function automatic int unsigned ded_count(input logic [MAP_MAX_W-1:0] map);
        int unsigned n;
        n = 0;
        for (int i = 0; i < MAP_MAX_W; i++) begin
            if (map[i]) n++;
        end
        return n;
    endfunction

    // dedicated pin slot serving output idx: count of mapped outputs below it
    function automatic int unsigned ded_slot(input logic [MAP_MAX_W-1:0] map,
                                             input int unsigned idx);
        int unsigned n;
        n = 0;
        for (int i = 0; i < MAP_MAX_W; i++) begin
            if (i < int'(idx) && map[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/pwm_gate_sync.sv
module pwm_gate_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwm_gate_route.sv
module pwm_gate_route
    import pwm_gate_pkg::*;
#(
    parameter int unsigned        NUM_OUT = 16,
    parameter logic [NUM_OUT-1:0] DED_MAP = 16'hC3C3,
    parameter int unsigned        NUM_DED = 8
) (
    input  logic [NUM_DED-1:0] ded_i,
    output logic [NUM_OUT-1:0] ded_full_o
);

    localparam logic [MAP_MAX_W-1:0] MAP_EXT = MAP_MAX_W'(DED_MAP);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        if (DED_MAP[o]) begin : g_has
            localparam int unsigned SLOT = ded_slot(MAP_EXT, o);
            assign ded_full_o[o] = ded_i[SLOT];
        end else begin : g_none
            assign ded_full_o[o] = 1'b0;
        end
    end

endmodule

// File: rtl/pwm_gate_select.sv
module pwm_gate_select
    import pwm_gate_pkg::*;
#(
    parameter int unsigned NUM_OUT = 16
) (
    input  logic [NUM_OUT-1:0] on_i,
    input  logic [NUM_OUT-1:0] en_i,
    input  logic [NUM_OUT-1:0] or_sel_i,
    input  logic               glb_i,
    input  logic [NUM_OUT-1:0] ded_i,
    output logic [NUM_OUT-1:0] pre_o
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_sel
        always_comb begin
            if (en_i[o]) begin
                unique case (comb_mode_e'(or_sel_i[o]))
                    COMB_OR:  pre_o[o] = glb_i | on_i[o];
                    default:  pre_o[o] = glb_i & on_i[o];
                endcase
            end else begin
                pre_o[o] = on_i[o] | ded_i[o];
            end
        end
    end

endmodule

// File: rtl/pwm_gate_matrix.sv
module pwm_gate_matrix
    import pwm_gate_pkg::*;
#(
    parameter int unsigned        NUM_OUT     = 16,
    parameter logic [NUM_OUT-1:0] DED_MAP     = 16'hC3C3,
    parameter int unsigned        NUM_DED     = ded_count(MAP_MAX_W'(DED_MAP)),
    parameter int unsigned        SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_OUT-1:0] out_on_i,
    input  logic [NUM_OUT-1:0] pwm_en_i,
    input  logic [NUM_OUT-1:0] pwm_or_i,
    input  logic               pwm_glb_i,
    input  logic [NUM_DED-1:0] pwm_ded_i,
    input  logic [NUM_OUT-1:0] shdn_i,
    input  logic               shdn_all_i,
    output logic [NUM_OUT-1:0] gate_o
);

    localparam int unsigned PIN_W = NUM_DED + 1;

    typedef struct packed {
        logic [NUM_OUT-1:0] gate;
    } gate_state_t;

    logic [PIN_W-1:0]   pins_sync;
    logic [NUM_OUT-1:0] ded_full;
    logic [NUM_OUT-1:0] gate_pre;
    gate_state_t        st_d, st_q;

    pwm_gate_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({pwm_ded_i, pwm_glb_i}),
        .sync_o  (pins_sync)
    );

    pwm_gate_route #(
        .NUM_OUT (NUM_OUT),
        .DED_MAP (DED_MAP),
        .NUM_DED (NUM_DED)
    ) u_route (
        .ded_i      (pins_sync[PIN_W-1:1]),
        .ded_full_o (ded_full)
    );

    pwm_gate_select #(
        .NUM_OUT (NUM_OUT)
    ) u_select (
        .on_i     (out_on_i),
        .en_i     (pwm_en_i),
        .or_sel_i (pwm_or_i),
        .glb_i    (pins_sync[0]),
        .ded_i    (ded_full),
        .pre_o    (gate_pre)
    );

    always_comb begin
        st_d      = st_q;
        st_d.gate = gate_pre & ~shdn_i & ~{NUM_OUT{shdn_all_i}};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.gate;

endmodule

// File: rtl/pwm_gate_matrix_chk.sv
module pwm_gate_matrix_chk #(
    parameter int unsigned        NUM_OUT = 16,
    parameter logic [NUM_OUT-1:0] DED_MAP = 16'hC3C3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_OUT-1:0] out_on_i,
    input logic [NUM_OUT-1:0] pwm_en_i,
    input logic [NUM_OUT-1:0] shdn_i,
    input logic               shdn_all_i,
    input logic [NUM_OUT-1:0] gate_o
);

    localparam logic [NUM_OUT-1:0] PLAIN = ~DED_MAP;

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        (!rst_ni && $past(!rst_ni)) |-> (gate_o == '0));

    // R9
    shdn_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shdn_all_i |=> (gate_o == '0));

    // R8
    unit_shdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|shdn_i) |=> ((gate_o & $past(shdn_i)) == '0));

    // R7
    plain_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(PLAIN & ~pwm_en_i)) |=>
        (((gate_o ^ $past(out_on_i & ~shdn_i & ~{NUM_OUT{shdn_all_i}}))
          & PLAIN & ~$past(pwm_en_i)) == '0));

endmodule

bind pwm_gate_matrix pwm_gate_matrix_chk #(
    .NUM_OUT (NUM_OUT),
    .DED_MAP (DED_MAP)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .out_on_i   (out_on_i),
    .pwm_en_i   (pwm_en_i),
    .shdn_i     (shdn_i),
    .shdn_all_i (shdn_all_i),
    .gate_o     (gate_o)
);

// File: tb/tb_pwm_gate_matrix.sv
module tb_pwm_gate_matrix;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] on_r = '0, en_r = '0, or_r = '0, sd_r = '0;
    logic        glb = 1'b0, sd_all = 1'b0;
    logic [7:0]  ded = '0;
    logic [15:0] gate;

    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";
    logic [15:0] exp_gate = '0;
    logic [8:0]  pin_hist[$];
    int    ded_of[16];

    always #2.5 clk = ~clk;

    pwm_gate_matrix dut (
        .clk_i(clk), .rst_ni(rst_n), .out_on_i(on_r), .pwm_en_i(en_r),
        .pwm_or_i(or_r), .pwm_glb_i(glb), .pwm_ded_i(ded),
        .shdn_i(sd_r), .shdn_all_i(sd_all), .gate_o(gate)
    );

    // dedicated pin k serves outputs 0,1,6,7,8,9,14,15 in that order (R6)
    initial begin
        int outs[8] = '{0, 1, 6, 7, 8, 9, 14, 15};
        for (int o = 0; o < 16; o++) ded_of[o] = -1;
        for (int k = 0; k < 8; k++) ded_of[outs[k]] = k;
        pin_hist = {9'd0, 9'd0};
    end

    // behavioural model: pins seen two clocks late, gate registered
    always @(posedge clk) begin
        logic [8:0] seen;
        logic       bit_v;
        if (!rst_n) begin
            exp_gate = '0;
            pin_hist = {9'd0, 9'd0};
        end else begin
            seen = pin_hist[0];
            for (int o = 0; o < 16; o++) begin
                if (en_r[o]) bit_v = or_r[o] ? (seen[0] | on_r[o]) : (seen[0] & on_r[o]);
                else if (ded_of[o] >= 0) bit_v = on_r[o] | seen[1 + ded_of[o]];
                else bit_v = on_r[o];
                if (sd_r[o] || sd_all) bit_v = 1'b0;
                exp_gate[o] = bit_v;
            end
            void'(pin_hist.pop_front());
            pin_hist.push_back({ded, glb});
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: gate actual %h expected %h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(cur_req, gate, exp_gate);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state, with inputs active
        on_r = 16'hFFFF; ded = 8'hFF; glb = 1'b1;
        step(4);
        check("R1", gate, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        on_r = '0; ded = '0; glb = 1'b0;
        step(3);
        check("R1", gate, 16'h0000);

        // R5 R7: PWM disabled, shared pin toggles
        cur_req = "R5 R7";
        on_r = 16'hA55A;
        for (int i = 0; i < 12; i++) begin glb = ~glb; step(1); end
        check("R7", gate, 16'hA55A);

        // R6 dedicated pins with PWM disabled
        cur_req = "R6";
        on_r = 16'h0000;
        ded = 8'h01; step(4); check("R6", gate, 16'h0001);
        ded = 8'h04; step(4); check("R6", gate, 16'h0040);
        ded = 8'h80; step(4); check("R6", gate, 16'h8000);
        ded = 8'h30; on_r = 16'h0010; step(4); check("R6", gate, 16'h0310);

        // R2 AND mode, R4 dedicated pins ignored
        cur_req = "R2 R4";
        en_r = 16'hFFFF; or_r = '0; on_r = 16'h0F0F; ded = 8'hFF;
        for (int i = 0; i < 10; i++) begin glb = (i % 3) != 0; step(2); end
        glb = 1'b0; step(4); check("R4", gate, 16'h0000);
        glb = 1'b1; step(4); check("R2", gate, 16'h0F0F);

        // R3 OR mode
        cur_req = "R3";
        or_r = 16'hFFFF; on_r = 16'h00F0; ded = 8'h00;
        glb = 1'b0; step(4); check("R3", gate, 16'h00F0);
        glb = 1'b1; step(4); check("R3", gate, 16'hFFFF);

        // R10 latency of a pin and of a control bit
        cur_req = "R10";
        en_r = 16'h0001; or_r = 16'h0001; on_r = '0; glb = 1'b0; ded = '0;
        step(4);
        glb = 1'b1;
        step(1); check("R10", gate & 16'h0001, 16'h0000);
        step(1); check("R10", gate & 16'h0001, 16'h0000);
        step(1); check("R10", gate & 16'h0001, 16'h0001);
        on_r = 16'h0004;
        step(1); check("R10", gate & 16'h0004, 16'h0004);

        // mixed random patterns
        cur_req = "R2 R3 R4 R5 R6 R7";
        for (int i = 0; i < 300; i++) begin
            on_r = 16'($urandom); en_r = 16'($urandom); or_r = 16'($urandom);
            glb = 1'($urandom); ded = 8'($urandom);
            step(1);
        end

        // R8 per-output shutdown, R9 global shutdown
        cur_req = "R8";
        en_r = '0; on_r = 16'hFFFF; sd_r = 16'h1234;
        step(2); check("R8", gate, 16'hEDCB);
        for (int i = 0; i < 100; i++) begin
            sd_r = 16'($urandom); on_r = 16'($urandom); en_r = 16'($urandom);
            or_r = 16'($urandom); glb = 1'($urandom); ded = 8'($urandom);
            step(1);
        end
        cur_req = "R9";
        sd_r = '0; on_r = 16'hFFFF; or_r = 16'hFFFF; glb = 1'b1; sd_all = 1'b1;
        step(4); check("R9", gate, 16'h0000);
        sd_all = 1'b0; step(1); check("R9", gate, 16'hFFFF);

        // R1 reset in mid-operation
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        #1 check("R1", gate, 16'h0000);
        step(3);
        rst_n = 1'b1; on_r = '0; en_r = '0; glb = 1'b0; ded = '0;
        step(3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule